// File: doc/BRIEF.md
# Two-Level Snapshot Bus Arbiter

This block decides which of up to seven masters may drive a shared bus. Slot 0 is the host bridge's own request path; slots 1 to 6 belong to external masters. Each slot has an enable bit and a priority bit, and both are loaded through a small write-only configuration port. Grants are one-hot and registered. A grant moves only at a point where it may do so safely: the owner has dropped its request, the owner has been disabled, or the bus is idle and a timer has forced a release.

Requests are captured into two snapshot masks, one for each priority level. The arbiter serves every captured high-priority slot in ascending slot order. It then serves exactly one captured low-priority slot, the lowest numbered one, and after that takes fresh snapshots. Low-priority masters therefore always progress, while high-priority masters get most of the bus.

Two timers guard the owner. The first is a broken-master timeout: if it is enabled and the owner leaves the bus idle for a fixed number of clocks after its grant, the grant is withdrawn. The second is a fairness budget with a programmable start value. It counts the owner's busy cycles and, once the budget is spent, hands the bus on at the next idle cycle, even if the owner keeps requesting.

Top module: `snap_bus_arbiter`

## Requirements
- R1: After reset no grant is asserted, all slots are enabled, only slot 0 is high priority, the timeout is off and the fairness start value is 0.
- R2: A write with `cfg_addr_i`=1 loads the enable mask from `cfg_wdata_i[6:0]` (bit n is slot n). A slot whose bit is 0 is not granted from the second clock edge after the write onwards. A disabled owner loses its grant at that edge.
- R3: A write with `cfg_addr_i`=2 loads the priority mask from `cfg_wdata_i[6:0]`, where bit n set to 1 makes slot n high priority. With the reset value 0x01 and slots 0, 1 and 2 each requesting again one cycle after release, the grant order is 0, 1, 0, 2.
- R4: A snapshot captures the enabled requests of each level. Captured high-priority slots are granted in ascending order. Then the lowest captured low-priority slot is granted, and the next decision takes new snapshots.
- R5: A write with `cfg_addr_i`=0 sets the timeout enable from `cfg_wdata_i[0]`. When it is enabled and the bus stays idle for 16 clocks from the grant without a busy cycle, the grant is removed after exactly 16 cycles. A busy cycle after the grant cancels the timeout.
- R6: The same write loads the fairness start value from `cfg_wdata_i[15:8]`. The counter is loaded at each grant and decremented on each busy cycle. At an idle cycle after the owner has started, a counter of 0 forces a new decision.
- R7: At most one grant is asserted. While the owner keeps requesting, stays enabled and the bus is busy, the grant does not change.
- R8: With no enabled request pending, no grant is asserted. A request is granted on the edge that follows the cycle in which it is seen, and only slots that were requesting in the previous cycle are granted.
- R9: A captured slot that has dropped its request is skipped. An owner released by the timeout or by the fairness budget is left out of the snapshot taken at that decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 7 | Request lines, one per slot, active high |
| bus_idle_i | input | 1 | High when no transaction is in progress on the bus |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 2 | Register select: 0 mode, 1 enable mask, 2 priority mask |
| cfg_wdata_i | input | 16 | Configuration write data |
| gnt_o | output | 7 | One-hot grant lines |

## Verification
The bench builds the block with the defaults: seven slots, a 16-clock timeout and an 8-bit fairness counter. With these values the bench can walk the whole timeout window one cycle at a time and can probe the fairness budget on both sides of expiry. Seven slots are few enough to trace two full high-then-low snapshot rounds by hand, and to check the default priority, the effect of a disabled slot and the skipping of a dropped captured request.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int unsigned CFG_AW = 2;

  typedef enum logic [CFG_AW-1:0] {
    CFG_MODE = 2'd0,
    CFG_EN   = 2'd1,
    CFG_PRI  = 2'd2
  } cfg_sel_e;
endpackage

// File: rtl/arb_lowest.sv
module arb_lowest #(
  parameter int unsigned N = 7
) (
  input  logic [N-1:0] vec_i,
  output logic [N-1:0] pick_o,
  output logic         any_o
);
  // isolate lowest set bit
  assign pick_o = vec_i & (~vec_i + N'(1));
  assign any_o  = |vec_i;
endmodule

// File: rtl/arb_cfg.sv
module arb_cfg
  import arb_pkg::*;
#(
  parameter int unsigned N      = 7,
  parameter int unsigned FAIR_W = 8,
  parameter int unsigned DW     = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CFG_AW-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [N-1:0]      en_o,
  output logic [N-1:0]      pri_o,
  output logic              to_en_o,
  output logic [FAIR_W-1:0] fair_start_o
);
  localparam int unsigned FAIR_LSB = 8;

  logic cfg_unused;
  assign cfg_unused = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o         <= '1;
      pri_o        <= N'(1);
      to_en_o      <= 1'b0;
      fair_start_o <= '0;
    end else if (we_i) begin
      if (addr_i == CFG_MODE) begin
        to_en_o      <= wdata_i[0];
        fair_start_o <= wdata_i[FAIR_LSB +: FAIR_W];
      end
      if (addr_i == CFG_EN)  en_o  <= wdata_i[N-1:0];
      if (addr_i == CFG_PRI) pri_o <= wdata_i[N-1:0];
    end
  end
endmodule

// File: rtl/arb_timer.sv
module arb_timer #(
  parameter int unsigned TIMEOUT = 16,
  parameter int unsigned FAIR_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              active_i,
  input  logic              bus_idle_i,
  input  logic              to_en_i,
  input  logic [FAIR_W-1:0] fair_start_i,
  output logic              to_fire_o,
  output logic              fair_exp_o
);
  localparam int unsigned TCW = $clog2(TIMEOUT + 1);
  localparam logic [TCW-1:0] TO_LAST = TCW'(TIMEOUT - 1);

  logic [TCW-1:0]    to_cnt_q;
  logic [FAIR_W-1:0] fair_q;
  logic              started_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      to_cnt_q  <= '0;
      fair_q    <= '0;
      started_q <= 1'b0;
    end else if (load_i) begin
      to_cnt_q  <= '0;
      fair_q    <= fair_start_i;
      started_q <= 1'b0;
    end else if (active_i) begin
      if (!bus_idle_i) begin
        started_q <= 1'b1;
        if (fair_q != '0) fair_q <= fair_q - FAIR_W'(1);
      end else if (!started_q && to_cnt_q != TO_LAST) begin
        to_cnt_q <= to_cnt_q + TCW'(1);
      end
    end
  end

  assign to_fire_o  = active_i && to_en_i && bus_idle_i && !started_q && (to_cnt_q == TO_LAST);
  assign fair_exp_o = active_i && bus_idle_i && started_q && (fair_q == '0);
endmodule

// File: rtl/arb_sched.sv
module arb_sched #(
  parameter int unsigned N = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] en_i,
  input  logic [N-1:0] pri_i,
  input  logic         to_fire_i,
  input  logic         fair_exp_i,
  output logic [N-1:0] gnt_o,
  output logic         load_o
);
  logic [N-1:0] own_q, hi_q, lo_q;
  logic [N-1:0] own_d, hi_d, lo_d;
  logic [N-1:0] live, excl, eff_hi, eff_lo, new_hi, new_lo;
  logic [N-1:0] pk_hi, pk_lo, pk_nhi, pk_nlo;
  logic         any_hi, any_lo, any_nhi, any_nlo;
  logic         forced, rearb;

  assign forced = to_fire_i | fair_exp_i;
  assign rearb  = ~|own_q || ~|(own_q & req_i) || ~|(own_q & en_i) || forced;

  assign live   = req_i & en_i;
  assign excl   = forced ? own_q : '0;
  assign eff_hi = hi_q & live;
  assign eff_lo = lo_q & live;
  assign new_hi = live & pri_i & ~excl;
  assign new_lo = live & ~pri_i & ~excl;

  arb_lowest #(.N(N)) u_pk_hi  (.vec_i(eff_hi), .pick_o(pk_hi),  .any_o(any_hi));
  arb_lowest #(.N(N)) u_pk_lo  (.vec_i(eff_lo), .pick_o(pk_lo),  .any_o(any_lo));
  arb_lowest #(.N(N)) u_pk_nhi (.vec_i(new_hi), .pick_o(pk_nhi), .any_o(any_nhi));
  arb_lowest #(.N(N)) u_pk_nlo (.vec_i(new_lo), .pick_o(pk_nlo), .any_o(any_nlo));

  always_comb begin
    own_d = own_q;
    hi_d  = hi_q;
    lo_d  = lo_q;
    if (rearb) begin
      if (any_hi) begin
        own_d = pk_hi;
        hi_d  = eff_hi & ~pk_hi;
      end else if (any_lo) begin
        // one low-level slot closes the round
        own_d = pk_lo;
        hi_d  = '0;
        lo_d  = '0;
      end else if (any_nhi) begin
        own_d = pk_nhi;
        hi_d  = new_hi & ~pk_nhi;
        lo_d  = new_lo;
      end else if (any_nlo) begin
        own_d = pk_nlo;
        hi_d  = '0;
        lo_d  = '0;
      end else begin
        own_d = '0;
        hi_d  = '0;
        lo_d  = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_q <= '0;
      hi_q  <= '0;
      lo_q  <= '0;
    end else begin
      own_q <= own_d;
      hi_q  <= hi_d;
      lo_q  <= lo_d;
    end
  end

  assign gnt_o  = own_q;
  assign load_o = rearb && (|own_d);

  // R4: a slot sits in at most one snapshot level
  a_r4_snap_disjoint: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_q & lo_q) == '0);

  // R4: the current owner is no longer pending in the high snapshot
  a_r4_owner_served: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_q & hi_q) == '0);
endmodule

// File: rtl/snap_bus_arbiter.sv
module snap_bus_arbiter
  import arb_pkg::*;
#(
  parameter int unsigned NUM_REQ = 7,
  parameter int unsigned TIMEOUT = 16,
  parameter int unsigned FAIR_W  = 8,
  parameter int unsigned CFG_DW  = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_REQ-1:0] req_i,
  input  logic               bus_idle_i,
  input  logic               cfg_we_i,
  input  logic [CFG_AW-1:0]  cfg_addr_i,
  input  logic [CFG_DW-1:0]  cfg_wdata_i,
  output logic [NUM_REQ-1:0] gnt_o
);
  logic [NUM_REQ-1:0] en_w, pri_w;
  logic               to_en_w, to_fire_w, fair_exp_w, load_w;
  logic [FAIR_W-1:0]  fair_start_w;

  arb_cfg #(.N(NUM_REQ), .FAIR_W(FAIR_W), .DW(CFG_DW)) u_cfg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .we_i         (cfg_we_i),
    .addr_i       (cfg_addr_i),
    .wdata_i      (cfg_wdata_i),
    .en_o         (en_w),
    .pri_o        (pri_w),
    .to_en_o      (to_en_w),
    .fair_start_o (fair_start_w)
  );

  arb_timer #(.TIMEOUT(TIMEOUT), .FAIR_W(FAIR_W)) u_timer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (load_w),
    .active_i     (|gnt_o),
    .bus_idle_i   (bus_idle_i),
    .to_en_i      (to_en_w),
    .fair_start_i (fair_start_w),
    .to_fire_o    (to_fire_w),
    .fair_exp_o   (fair_exp_w)
  );

  arb_sched #(.N(NUM_REQ)) u_sched (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .en_i       (en_w),
    .pri_i      (pri_w),
    .to_fire_i  (to_fire_w),
    .fair_exp_i (fair_exp_w),
    .gnt_o      (gnt_o),
    .load_o     (load_w)
  );

  a_r7_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));

  a_r7_change_point: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|$past(gnt_o)) && (gnt_o != $past(gnt_o))) |->
      ($past(bus_idle_i) || ($past(req_i & gnt_o) == '0) || ($past(en_w & gnt_o) == '0)));

  a_r2_no_disabled_gnt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~$past(en_w)) == '0);

  a_r8_gnt_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~$past(req_i)) == '0);
endmodule

// File: tb/tb_snap_bus_arbiter.sv
module tb_snap_bus_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int N = 7;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] req = '0;
  logic         bus_idle = 1'b1;
  logic         cfg_we = 1'b0;
  logic [1:0]   cfg_addr = '0;
  logic [15:0]  cfg_wdata = '0;
  logic [N-1:0] gnt;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  snap_bus_arbiter dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .req_i       (req),
    .bus_idle_i  (bus_idle),
    .cfg_we_i    (cfg_we),
    .cfg_addr_i  (cfg_addr),
    .cfg_wdata_i (cfg_wdata),
    .gnt_o       (gnt)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: gnt actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; req = '0; bus_idle = 1'b1; cfg_we = 1'b0;
    step(); step();
    rst_ni = 1'b1;
    step();
  endtask

  task automatic cfg_write(input logic [1:0] a, input logic [15:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    step();
    cfg_we = 1'b0;
  endtask

  // owner releases its request for one cycle after each grant
  task automatic release_walk(input string tag, input logic [N-1:0] base, input int exp_q[]);
    foreach (exp_q[k]) begin
      req = base & ~gnt;
      step();
      chk(tag, gnt, N'(1 << exp_q[k]));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R1 reset state and default enables
    do_reset();
    chk("R1 reset", gnt, '0);
    req = 7'h40;
    step();
    chk("R1 default enable / R8 one-cycle grant", gnt, 7'h40);

    // R3 default priority: slot 0 high only
    do_reset();
    release_walk("R3 default priority", 7'h07, '{0, 1, 0, 2});

    // R4 snapshot rounds with slots 0,1,3 high
    do_reset();
    cfg_write(2'd2, 16'h000B);
    chk("R3 write no grant", gnt, '0);
    release_walk("R4 snapshot order", 7'h7F, '{0, 1, 3, 2, 0, 1, 3, 4, 0, 1, 3, 2});

    // R2 enable mask
    do_reset();
    cfg_write(2'd1, 16'h007B);
    cfg_write(2'd2, 16'h0000);
    req = 7'h06;
    step();
    chk("R2 masked slot skipped", gnt, 7'h02);
    req = 7'h04;
    step();
    chk("R2 disabled slot not granted", gnt, '0);
    step(); step();
    chk("R2 disabled slot stays ungranted", gnt, '0);
    cfg_write(2'd1, 16'h007F);
    step();
    chk("R2 re-enabled slot granted", gnt, 7'h04);
    cfg_write(2'd1, 16'h007B);
    step();
    chk("R2 owner disabled loses grant", gnt, '0);

    // R5 timeout window
    do_reset();
    cfg_write(2'd0, 16'h0001);
    req = 7'h08;
    step();
    chk("R5 grant cycle 1", gnt, 7'h08);
    for (int i = 2; i <= 16; i++) begin
      step();
      chk("R5 grant held within window", gnt, 7'h08);
    end
    step();
    chk("R5 grant withdrawn after 16 idle cycles", gnt, '0);
    step();
    chk("R9 next snapshot regrants", gnt, 7'h08);

    do_reset();
    req = 7'h08;
    step();
    for (int i = 0; i < 30; i++) step();
    chk("R5 timeout disabled keeps grant", gnt, 7'h08);

    do_reset();
    cfg_write(2'd0, 16'hFF01);
    req = 7'h08;
    step();
    for (int i = 0; i < 5; i++) step();
    bus_idle = 1'b0;
    step();
    bus_idle = 1'b1;
    for (int i = 0; i < 30; i++) step();
    chk("R5 busy cycle cancels timeout", gnt, 7'h08);

    // R6 fairness budget
    do_reset();
    req = 7'h12;
    step();
    chk("R6 first owner", gnt, 7'h02);
    bus_idle = 1'b0;
    for (int i = 0; i < 3; i++) step();
    chk("R7 busy bus holds grant", gnt, 7'h02);
    bus_idle = 1'b1;
    step();
    chk("R6 zero budget hands over at idle", gnt, 7'h10);

    do_reset();
    cfg_write(2'd0, 16'h0A00);
    req = 7'h12;
    step();
    chk("R6 first owner budget 10", gnt, 7'h02);
    bus_idle = 1'b0;
    for (int i = 0; i < 3; i++) step();
    bus_idle = 1'b1;
    step();
    chk("R6 budget left after 3 busy", gnt, 7'h02);
    bus_idle = 1'b0;
    for (int i = 0; i < 6; i++) step();
    bus_idle = 1'b1;
    step();
    chk("R6 budget left after 9 busy", gnt, 7'h02);
    bus_idle = 1'b0;
    step();
    bus_idle = 1'b1;
    step();
    chk("R6 budget spent after 10 busy", gnt, 7'h10);

    // R9 dropped captured request skipped, R8 idle
    do_reset();
    cfg_write(2'd2, 16'h007F);
    req = 7'h0E;
    step();
    chk("R9 first high owner", gnt, 7'h02);
    req = 7'h08;
    step();
    chk("R9 dropped slot skipped", gnt, 7'h08);
    req = '0;
    step();
    chk("R8 no request no grant", gnt, '0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule